// File: doc/BRIEF.md
# Masked Time Alarm Interrupt Unit

This block watches a running clock/calendar and raises an interrupt when the time reaches a programmed alarm. Four alarm registers hold target values for seconds, minutes, hours and date. The top bit of each register is a mask bit, and the four mask bits together choose how coarse the match is. The choices run from firing every second up to a full date-and-time match. Any mask pattern outside the supported set falls back to firing every second.

The unit compares once per second tick. A hit sets a sticky alarm flag. The flag drives an open-drain, active-low interrupt, which is modelled here as a pull-down enable. Whether the flag reaches the pin depends on the power state. On main power, only the alarm-enable bit must be set. During battery backup, the backup-enable bit must be set as well. Both enables are cleared by a power-up pulse.

Software acknowledges an alarm by reading or writing the flags register. The interrupt is released while that access is in progress, and the flag itself clears when the access ends. While in backup, all host accesses are ignored.

Top module: `alarm_intr_unit`

## Requirements
- R1: After reset the alarm flag, alarm-enable, backup-enable and all four alarm registers are 0, `irq_pull_o` is 0 and every readable address returns 0.
- R2: Alarm registers sit at addresses 2 (seconds), 3 (minutes), 4 (hours) and 5 (date). Each holds all 8 written bits and reads back unchanged. Address 6 is the enable register: bit 7 is alarm-enable, bit 5 is backup-enable, and its other bits read 0. Unmapped addresses read 0. A write occurs on any clock edge with `cs_i` and `wr_i` high. `rdata_o` follows `addr_i` combinationally.
- R3: Bit 7 of registers 5,4,3,2 forms the mask nibble, written MSB first. The nibble selects the match: 1111 means every tick; 1110 means seconds; 1100 means minutes and seconds; 1000 means hours, minutes and seconds; 0000 means date, hours, minutes and seconds. Each compare uses bits 6:0 of the register against the 7-bit time field. Matches are evaluated only on a cycle with `tick_i` high, and the flag is set at that clock edge.
- R4: Any mask nibble other than the five listed in R3 sets the flag on every tick.
- R5: The flags register is at address 0. It reads with the alarm flag at bit 6, the `batt_low_i` input at bit 4, and 0 in every other bit. Writes do not load it.
- R6: The flag is set on a match regardless of the enables. On main power, `irq_pull_o` is high exactly while the flag and alarm-enable are both 1 and no flags access is in progress.
- R7: With `backup_i` high, `irq_pull_o` additionally requires backup-enable to be 1.
- R8: A flags access means `cs_i` is high, `rd_i` or `wr_i` is high, and `addr_i` is 0. It forces `irq_pull_o` low in the same cycle. The flag clears at the first clock edge at which the access is no longer present. A tick that hits at that same edge keeps the flag set.
- R9: A `pwrup_i` cycle clears alarm-enable and backup-enable at that edge, with priority over a write. The alarm registers are left unchanged. A hit during that cycle still sets the flag.
- R10: While `backup_i` is high, writes have no effect, accesses do not release the interrupt or clear the flag, and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second, time fields already updated |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 7 | Current hours, BCD |
| date_i | input | 7 | Current day of month, BCD |
| backup_i | input | 1 | High while running from battery |
| pwrup_i | input | 1 | One-cycle power-up indication |
| batt_low_i | input | 1 | Battery-low status shown in the flags register |
| cs_i | input | 1 | Register select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| irq_pull_o | output | 1 | High pulls the open-drain interrupt line low; low leaves it released |

## Verification
The properties assume that `tick_i` and `pwrup_i` are single-cycle pulses. They also assume that time fields are stable on the tick cycle, and that a register access is a level held for whole clock cycles.

The stimulus changes every input on the falling clock edge. Each access is held for exactly one cycle and then dropped, so the end of a flags access always falls on a known edge. A tick is only ever combined with an access-end or a power-up pulse on purpose, to exercise the priority cases.

Backup mode is entered and left only between accesses. This keeps the rule that accesses are ignored in backup from being confused with an access that is cut off partway.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int unsigned FLAG_ADDR = 0;
  localparam int unsigned ALM_BASE  = 2;
  localparam int unsigned CTRL_ADDR = 6;
  localparam int unsigned AF_BIT    = 6;
  localparam int unsigned BATT_BIT  = 4;
  localparam int unsigned AE_BIT    = 7;
  localparam int unsigned ABE_BIT   = 5;
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4,
  parameter int unsigned NF = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_i,
  input  logic                   wr_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic                   pwrup_i,
  input  logic                   backup_i,
  input  logic                   af_i,
  input  logic                   batt_i,
  output logic [NF-1:0][DW-1:0]  alm_o,
  output logic                   ae_o,
  output logic                   abe_o,
  output logic [DW-1:0]          rdata_o
);
  logic [NF-1:0][DW-1:0] alm_q;
  logic ae_q, abe_q;
  logic wr_ok;

  assign wr_ok = cs_i & wr_i & ~backup_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= '0;
      ae_q  <= 1'b0;
      abe_q <= 1'b0;
    end else begin
      for (int i = 0; i < NF; i++)
        if (wr_ok && addr_i == AW'(ALM_BASE + i)) alm_q[i] <= wdata_i;
      if (pwrup_i) begin
        ae_q  <= 1'b0;
        abe_q <= 1'b0;
      end else if (wr_ok && addr_i == AW'(CTRL_ADDR)) begin
        ae_q  <= wdata_i[AE_BIT];
        abe_q <= wdata_i[ABE_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!backup_i) begin
      if (addr_i == AW'(FLAG_ADDR)) begin
        rdata_o[AF_BIT]   = af_i;
        rdata_o[BATT_BIT] = batt_i;
      end else if (addr_i == AW'(CTRL_ADDR)) begin
        rdata_o[AE_BIT]  = ae_q;
        rdata_o[ABE_BIT] = abe_q;
      end
      for (int i = 0; i < NF; i++)
        if (addr_i == AW'(ALM_BASE + i)) rdata_o = alm_q[i];
    end
  end

  assign alm_o = alm_q;
  assign ae_o  = ae_q;
  assign abe_o = abe_q;

  assert_pwrup_clears_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrup_i |=> (!ae_q && !abe_q));

  assert_frozen_in_backup_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backup_i && cs_i && wr_i) |=> $stable(alm_q));

  assert_backup_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backup_i |-> (rdata_o == '0));
endmodule

// File: rtl/alm_match.sv
module alm_match #(
  parameter int unsigned FW = 7,
  parameter int unsigned NF = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NF-1:0][FW:0]   alm_i,
  input  logic [NF-1:0][FW-1:0] tm_i,
  output logic                  hit_o
);
  logic [NF-1:0] eq, msk, ord_ok;
  logic mode_ok;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign eq[g]  = (alm_i[g][FW-1:0] == tm_i[g]);
    assign msk[g] = alm_i[g][FW];
    if (g < NF - 1) begin : g_ord
      // a masked field forces every coarser field to be masked
      assign ord_ok[g] = ~msk[g] | msk[g+1];
    end else begin : g_top
      assign ord_ok[g] = 1'b1;
    end
  end

  assign mode_ok = &ord_ok;
  assign hit_o   = ~mode_ok | (&(eq | msk));

  assert_all_masked_hits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&msk) |-> hit_o);

  assert_bad_mask_hits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_ok) |-> hit_o);
endmodule

// File: rtl/alm_irq.sv
module alm_irq
  import alm_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hit_i,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          backup_i,
  input  logic          ae_i,
  input  logic          abe_i,
  output logic          af_o,
  output logic          irq_pull_o
);
  logic af_q, acc, acc_q, set_af, clr_af, en;

  assign acc    = cs_i & (rd_i | wr_i) & (addr_i == AW'(FLAG_ADDR)) & ~backup_i;
  assign set_af = tick_i & hit_i;
  assign clr_af = acc_q & ~acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_q  <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      acc_q <= acc;
      if (set_af)      af_q <= 1'b1;
      else if (clr_af) af_q <= 1'b0;
    end
  end

  assign en         = backup_i ? (ae_i & abe_i) : ae_i;
  assign irq_pull_o = af_q & en & ~acc;
  assign af_o       = af_q;

  assert_flag_set_on_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hit_i) |=> af_q);

  assert_release_on_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && (rd_i || wr_i) && addr_i == AW'(FLAG_ADDR) && !backup_i) |-> !irq_pull_o);

  assert_clear_after_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q && !acc && !(tick_i && hit_i)) |=> !af_q);

  assert_backup_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backup_i && !(ae_i && abe_i)) |-> !irq_pull_o);

  assert_no_irq_without_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ae_i) |-> !irq_pull_o);
endmodule

// File: rtl/alarm_intr_unit.sv
module alarm_intr_unit #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned FW = DATA_W - 1,
  localparam int unsigned NF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [FW-1:0]     sec_i,
  input  logic [FW-1:0]     min_i,
  input  logic [FW-1:0]     hour_i,
  input  logic [FW-1:0]     date_i,
  input  logic              backup_i,
  input  logic              pwrup_i,
  input  logic              batt_low_i,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_pull_o
);
  logic [NF-1:0][DATA_W-1:0] alm;
  logic [NF-1:0][FW-1:0]     tm;
  logic ae, abe, af, hit;

  assign tm = {date_i, hour_i, min_i, sec_i};

  alm_regs #(.DW(DATA_W), .AW(ADDR_W), .NF(NF)) u_regs (
    .clk_i, .rst_ni, .cs_i, .wr_i, .addr_i, .wdata_i, .pwrup_i, .backup_i,
    .af_i(af), .batt_i(batt_low_i), .alm_o(alm), .ae_o(ae), .abe_o(abe),
    .rdata_o
  );

  alm_match #(.FW(FW), .NF(NF)) u_match (
    .clk_i, .rst_ni, .alm_i(alm), .tm_i(tm), .hit_o(hit)
  );

  alm_irq #(.AW(ADDR_W)) u_irq (
    .clk_i, .rst_ni, .tick_i, .hit_i(hit), .cs_i, .rd_i, .wr_i, .addr_i,
    .backup_i, .ae_i(ae), .abe_i(abe), .af_o(af), .irq_pull_o
  );
endmodule

// File: tb/sim_alarm_intr_unit.sv
module sim_alarm_intr_unit;
  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic clk = 0, rst_ni = 0;
  logic tick = 0, backup = 0, pwrup = 0, batt = 0;
  logic cs = 0, rd = 0, wr = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [6:0] sec = 0, mn = 0, hr = 0, dt = 0;
  logic [7:0] rdata;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;
  item_t sq[$];
  event smp;

  always #4 clk = ~clk;

  alarm_intr_unit u0 (
    .clk_i(clk), .rst_ni, .tick_i(tick), .sec_i(sec), .min_i(mn), .hour_i(hr),
    .date_i(dt), .backup_i(backup), .pwrup_i(pwrup), .batt_low_i(batt),
    .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_pull_o(irq)
  );

  // monitor: drains the scoreboard on each sample point
  initial forever begin
    @(smp);
    while (sq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sq.pop_front();
      act = it.is_irq ? {7'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s %s actual=%h expected=%h", it.req,
                 it.is_irq ? "irq" : "rdata", act, it.exp);
      end
    end
  end

  task automatic push(bit i, logic [7:0] e, string r);
    item_t it;
    it.is_irq = i; it.exp = e; it.req = r;
    sq.push_back(it);
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic chk_rd(logic [3:0] a, logic [7:0] e, string r);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #2; push(0, e, r); ->smp;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic chk_irq(bit e, string r);
    @(negedge clk); #2; push(1, {7'b0, e}, r); ->smp;
  endtask

  // flags read that also checks the interrupt is released mid-access
  task automatic chk_flag_rel(logic [7:0] e_rd, bit e_irq, string r);
    @(negedge clk); cs = 1; rd = 1; addr = 0;
    #2; push(0, e_rd, r); push(1, {7'b0, e_irq}, r); ->smp;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic do_tick(logic [6:0] s, logic [6:0] m, logic [6:0] h, logic [6:0] d);
    @(negedge clk); sec = s; mn = m; hr = h; dt = d; tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    chk_irq(0, "R1");
    chk_rd(0, 8'h00, "R1");
    chk_rd(2, 8'h00, "R1");
    chk_rd(5, 8'h00, "R1");
    chk_rd(6, 8'h00, "R1");
    // R2 register map
    wr_reg(3, 8'h5A); chk_rd(3, 8'h5A, "R2");
    wr_reg(6, 8'hFF); chk_rd(6, 8'hA0, "R2");
    chk_rd(9, 8'h00, "R2");
    // R3 mode 1110: seconds
    wr_reg(2, 8'h30); wr_reg(3, 8'h80); wr_reg(4, 8'h80); wr_reg(5, 8'h80);
    wr_reg(6, 8'h80);
    do_tick(7'h29, 7'h11, 7'h05, 7'h09); chk_irq(0, "R3");
    do_tick(7'h30, 7'h11, 7'h05, 7'h09); chk_irq(1, "R6");
    chk_flag_rel(8'h40, 0, "R8");
    chk_irq(0, "R8");
    // R3 mode 1100
    wr_reg(3, 8'h42);
    do_tick(7'h30, 7'h41, 7'h05, 7'h09); chk_irq(0, "R3");
    do_tick(7'h30, 7'h42, 7'h05, 7'h09); chk_irq(1, "R3");
    chk_flag_rel(8'h40, 0, "R8");
    // R3 mode 1000
    wr_reg(4, 8'h17);
    do_tick(7'h30, 7'h42, 7'h16, 7'h09); chk_irq(0, "R3");
    do_tick(7'h30, 7'h42, 7'h17, 7'h09); chk_irq(1, "R3");
    chk_flag_rel(8'h40, 0, "R8");
    // R3 mode 0000
    wr_reg(5, 8'h25);
    do_tick(7'h30, 7'h42, 7'h17, 7'h24); chk_irq(0, "R3");
    do_tick(7'h30, 7'h42, 7'h17, 7'h25); chk_irq(1, "R3");
    chk_flag_rel(8'h40, 0, "R8");
    // R3 mode 1111
    wr_reg(2, 8'h85); wr_reg(3, 8'h80); wr_reg(4, 8'h80); wr_reg(5, 8'h80);
    do_tick(7'h01, 7'h02, 7'h03, 7'h04); chk_irq(1, "R3");
    chk_flag_rel(8'h40, 0, "R8");
    // R4 unlisted 1010
    wr_reg(2, 8'h11); wr_reg(3, 8'h80); wr_reg(4, 8'h11); wr_reg(5, 8'h80);
    do_tick(7'h59, 7'h01, 7'h02, 7'h03); chk_irq(1, "R4");
    chk_flag_rel(8'h40, 0, "R4");
    // R4 unlisted 0111
    wr_reg(2, 8'h80); wr_reg(3, 8'h80); wr_reg(4, 8'h80); wr_reg(5, 8'h11);
    do_tick(7'h59, 7'h01, 7'h02, 7'h03); chk_irq(1, "R4");
    chk_flag_rel(8'h40, 0, "R4");
    // R6 flag without enable
    wr_reg(6, 8'h00);
    do_tick(7'h10, 7'h01, 7'h02, 7'h03); chk_irq(0, "R6");
    chk_rd(0, 8'h40, "R6");
    chk_rd(0, 8'h00, "R8");
    // R5 flags register
    batt = 1;
    chk_rd(0, 8'h10, "R5");
    wr_reg(0, 8'hFF);
    chk_rd(0, 8'h10, "R5");
    batt = 0;
    // R7 backup gating
    wr_reg(6, 8'h80);
    @(negedge clk); backup = 1;
    do_tick(7'h11, 7'h01, 7'h02, 7'h03); chk_irq(0, "R7");
    @(negedge clk); backup = 0;
    chk_irq(1, "R7");
    chk_flag_rel(8'h40, 0, "R8");
    wr_reg(6, 8'hA0);
    @(negedge clk); backup = 1;
    do_tick(7'h12, 7'h01, 7'h02, 7'h03); chk_irq(1, "R7");
    // R10 accesses ignored in backup
    chk_flag_rel(8'h00, 1, "R10");
    chk_irq(1, "R10");
    wr_reg(2, 8'h33);
    @(negedge clk); backup = 0;
    chk_rd(2, 8'h80, "R10");
    chk_flag_rel(8'h40, 0, "R10");
    // R9 power-up pulse with a hit in the same cycle
    wr_reg(6, 8'hA0);
    @(negedge clk); pwrup = 1; tick = 1;
    @(negedge clk); pwrup = 0; tick = 0;
    chk_irq(0, "R9");
    chk_rd(6, 8'h00, "R9");
    chk_rd(2, 8'h80, "R9");
    chk_rd(0, 8'h40, "R9");
    // R8 new hit on the access-end edge keeps the flag
    wr_reg(6, 8'h80);
    do_tick(7'h20, 7'h01, 7'h02, 7'h03); chk_irq(1, "R8");
    @(negedge clk); cs = 1; rd = 1; addr = 0;
    @(negedge clk); cs = 0; rd = 0; tick = 1;
    @(negedge clk); tick = 0;
    chk_irq(1, "R8");
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule